// File: doc/BRIEF.md
# Indirect PHY Register Access Engine

This block is a hardware master for a PHY whose 16-bit configuration registers are not memory-mapped. The PHY is reached through two words. The engine drives a 32-bit control word. It samples a 32-bit status word that returns an acknowledge flag and read data. Every transfer across this pair is a four-phase handshake. The engine raises a request bit and waits for acknowledge high. It then lowers the bit and waits for acknowledge low.

A client issues one access at a time on a simple request port: a direction flag, a 16-bit register address and 16-bit write data. Every access starts with an address-capture handshake. A read continues with a read-strobe handshake and latches the returned data. A write continues with a data-capture handshake and a write-strobe handshake, then clears the control word.

Each acknowledge wait samples the status word a bounded number of times at a fixed cycle interval. If the expected level never appears, the whole access is abandoned with a one-cycle error pulse and a cleared control word.

Top module: `phyx_xreg_engine`

## Requirements
- R1: After reset the control word is zero, `busy`, `done` and `err` are low and `rd_data` is zero.
- R2: Control word layout: bits 15:0 carry the address or data payload, bit 16 is capture-address, bit 17 is capture-data, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits 19:16 is set, and bits 31:20 are always zero. In the status word, bit 16 is the acknowledge flag and bits 15:0 are read data.
- R3: Address capture drives the address alone for one cycle. It then adds capture-address and waits for ack high. It then drops capture-address while keeping the address, and waits for ack low.
- R4: A read follows address capture with the read strobe alone and waits for ack high. At the sample that sees ack high, it latches status bits 15:0 into `rd_data`. It then drives zero and waits for ack low. `rd_data` changes at no other time.
- R5: A write follows address capture with three steps. First it drives the data alone for one cycle. Then it runs a capture-data handshake with the data kept in bits 15:0 (data plus bit 17, wait high; data, wait low). Then it runs a write-strobe handshake (bit 18 alone, wait high; data, wait low). In its final `done` cycle the control word is zero.
- R6: In every acknowledge wait, the status word is sampled in the first cycle of the step and then every `POLL_CYC` cycles. The step advances in the cycle after the first sample that shows the expected level.
- R7: If `MAX_POLLS` samples in one wait fail, the next cycle drives a zero control word with `err` high for one cycle. The engine then returns to idle without a `done` pulse.
- R8: A request (`req_valid` high at a clock edge) is accepted only when idle. `busy` rises in the next cycle and stays high through the single `done` or `err` cycle. Requests arriving while busy are ignored. `done` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an access (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Data for a write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse: access completed |
| err | output | 1 | One-cycle pulse: acknowledge timeout |
| rd_data | output | 16 | Data of the last completed read |
| ctrl_word | output | 32 | Control word driven to the PHY bridge |
| stat_word | input | 32 | Status word from the PHY bridge |

## Verification
The accesses run against a behavioural responder whose acknowledge latency is varied. At zero latency every wait resolves on its first sample. At a few cycles of latency the wait resolves on a later sample. At a latency just inside the poll window the wait resolves near its last sample. These cases separate correct sample spacing from early or late advancement. A responder stuck low exercises the timeout of a high wait, and one stuck high exercises the timeout of a low wait. A latency beyond the window shows the limit counted in samples rather than in cycles. Writes followed by reads of the same and of unwritten addresses check data placement and latching. A request pulsed in the middle of an access must leave both the trace and the stored register untouched.

// File: rtl/phyx_pkg.sv
package phyx_pkg;
   // Field positions the PHY bridge decodes; fixed by the neighbour block.
   localparam int CTRL_W    = 32;
   localparam int STAT_W    = 32;
   localparam int PAY_W     = 16;
   localparam int BIT_CAPA  = 16;
   localparam int BIT_CAPD  = 17;
   localparam int BIT_WSTB  = 18;
   localparam int BIT_RSTB  = 19;
   localparam int BIT_ACK   = 16;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_A_SET,
      ST_A_HI,
      ST_A_LO,
      ST_R_HI,
      ST_R_LO,
      ST_D_SET,
      ST_D_HI,
      ST_D_LO,
      ST_W_HI,
      ST_W_LO,
      ST_FIN,
      ST_ABORT
   } phyx_state_e;

   typedef enum logic [1:0] {
      WT_NONE,
      WT_HIGH,
      WT_LOW
   } phyx_wait_e;
endpackage

// File: rtl/phyx_poll_timer.sv
module phyx_poll_timer #(
   parameter int POLL_CYC  = 4,
   parameter int MAX_POLLS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic active,
   output logic sample,
   output logic final_poll
);
   localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

   logic [PW-1:0] polls_q;

   generate
      if (POLL_CYC == 1) begin : g_every_cycle
         assign sample = active;
      end else begin : g_interval
         localparam int IW = $clog2(POLL_CYC);
         logic [IW-1:0] gap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               gap_q <= '0;
            end else if (restart) begin
               gap_q <= '0;
            end else if (active) begin
               if (gap_q == '0) gap_q <= IW'(POLL_CYC - 1);
               else             gap_q <= gap_q - 1'b1;
            end
         end
         assign sample = active && (gap_q == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         polls_q <= '0;
      end else if (restart) begin
         polls_q <= '0;
      end else if (sample && !final_poll) begin
         polls_q <= polls_q + 1'b1;
      end
   end

   assign final_poll = (polls_q == PW'(MAX_POLLS - 1));
endmodule

// File: rtl/phyx_ctrl_encode.sv
module phyx_ctrl_encode
   import phyx_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  phyx_state_e         state,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   data,
   output logic [CTRL_W-1:0]   ctrl,
   output phyx_wait_e          wait_kind
);
   logic [CTRL_W-1:0] addr_field;
   logic [CTRL_W-1:0] data_field;

   assign addr_field = CTRL_W'(addr);
   assign data_field = CTRL_W'(data);

   always_comb begin
      ctrl      = '0;
      wait_kind = WT_NONE;
      unique case (state)
         ST_A_SET: ctrl = addr_field;
         ST_A_HI: begin
            ctrl      = addr_field;
            ctrl[BIT_CAPA] = 1'b1;
            wait_kind = WT_HIGH;
         end
         ST_A_LO: begin
            ctrl      = addr_field;
            wait_kind = WT_LOW;
         end
         ST_R_HI: begin
            ctrl[BIT_RSTB] = 1'b1;
            wait_kind = WT_HIGH;
         end
         ST_R_LO: wait_kind = WT_LOW;
         ST_D_SET: ctrl = data_field;
         ST_D_HI: begin
            ctrl      = data_field;
            ctrl[BIT_CAPD] = 1'b1;
            wait_kind = WT_HIGH;
         end
         ST_D_LO: begin
            ctrl      = data_field;
            wait_kind = WT_LOW;
         end
         ST_W_HI: begin
            ctrl[BIT_WSTB] = 1'b1;
            wait_kind = WT_HIGH;
         end
         ST_W_LO: begin
            ctrl      = data_field;
            wait_kind = WT_LOW;
         end
         default: begin
            ctrl      = '0;
            wait_kind = WT_NONE;
         end
      endcase
   end
endmodule

// File: rtl/phyx_seq.sv
module phyx_seq
   import phyx_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              ack,
   input  logic [DATA_W-1:0] rd_field,
   input  phyx_wait_e        wait_kind,
   input  logic              sample,
   input  logic              final_poll,
   output phyx_state_e       state,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              restart,
   output logic              busy,
   output logic              done,
   output logic              err
);
   phyx_state_e state_q, state_d;
   logic        write_q;
   logic        level_met;
   logic        step_ok;
   logic        step_fail;

   assign level_met = (wait_kind == WT_HIGH) ? ack : !ack;
   assign step_ok   = sample && level_met;
   assign step_fail = sample && !level_met && final_poll;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req_valid) state_d = ST_A_SET;
         ST_A_SET: state_d = ST_A_HI;
         ST_A_HI:  if (step_ok) state_d = ST_A_LO;
         ST_A_LO:  if (step_ok) state_d = write_q ? ST_D_SET : ST_R_HI;
         ST_R_HI:  if (step_ok) state_d = ST_R_LO;
         ST_R_LO:  if (step_ok) state_d = ST_FIN;
         ST_D_SET: state_d = ST_D_HI;
         ST_D_HI:  if (step_ok) state_d = ST_D_LO;
         ST_D_LO:  if (step_ok) state_d = ST_W_HI;
         ST_W_HI:  if (step_ok) state_d = ST_W_LO;
         ST_W_LO:  if (step_ok) state_d = ST_FIN;
         default:  state_d = ST_IDLE;
      endcase
      if ((wait_kind != WT_NONE) && step_fail) state_d = ST_ABORT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         write_q <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
         rd_data <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && req_valid) begin
            write_q <= req_write;
            addr_q  <= req_addr;
            data_q  <= req_wdata;
         end
         if (state_q == ST_R_HI && step_ok) rd_data <= rd_field;
      end
   end

   assign state   = state_q;
   assign restart = (state_d != state_q);
   assign busy    = (state_q != ST_IDLE);
   assign done    = (state_q == ST_FIN);
   assign err     = (state_q == ST_ABORT);
endmodule

// File: rtl/phyx_xreg_engine.sv
module phyx_xreg_engine
   import phyx_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int POLL_CYC  = 4,
   parameter int MAX_POLLS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rd_data,
   output logic [CTRL_W-1:0] ctrl_word,
   input  logic [STAT_W-1:0] stat_word
);
   generate
      if (ADDR_W < 1 || ADDR_W > PAY_W) begin : g_bad_addr
         $error("ADDR_W must lie in 1..16");
      end
      if (DATA_W < 1 || DATA_W > PAY_W) begin : g_bad_data
         $error("DATA_W must lie in 1..16");
      end
      if (POLL_CYC < 1) begin : g_bad_poll
         $error("POLL_CYC must be at least 1");
      end
      if (MAX_POLLS < 1) begin : g_bad_max
         $error("MAX_POLLS must be at least 1");
      end
   endgenerate

   phyx_state_e       state;
   phyx_wait_e        wait_kind;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              restart;
   logic              sample;
   logic              final_poll;
   logic              unused_stat;

   assign unused_stat = ^{stat_word[STAT_W-1:BIT_ACK+1], stat_word[PAY_W-1:0]};

   phyx_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .ack        (stat_word[BIT_ACK]),
      .rd_field   (stat_word[DATA_W-1:0]),
      .wait_kind  (wait_kind),
      .sample     (sample),
      .final_poll (final_poll),
      .state      (state),
      .addr_q     (addr_q),
      .data_q     (data_q),
      .rd_data    (rd_data),
      .restart    (restart),
      .busy       (busy),
      .done       (done),
      .err        (err)
   );

   phyx_ctrl_encode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_enc (
      .state     (state),
      .addr      (addr_q),
      .data      (data_q),
      .ctrl      (ctrl_word),
      .wait_kind (wait_kind)
   );

   phyx_poll_timer #(.POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .active     (wait_kind != WT_NONE),
      .sample     (sample),
      .final_poll (final_poll)
   );
endmodule

// File: rtl/phyx_xreg_checker.sv
module phyx_xreg_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [DATA_W-1:0] rd_data,
   input logic [31:0]       ctrl_word
);
   a_r2_one_request_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctrl_word[19:16]));

   a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_word[31:20] == 12'h000);

   a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   a_r8_accept_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> busy);

   a_r8_end_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |=> !busy);

   a_r8_pulse_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> busy);

   a_r7_abort_clears_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (ctrl_word == 32'h0));

   a_r5_done_clears_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ctrl_word == 32'h0));

   a_r4_rd_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_word[19] |=> $stable(rd_data));

   a_r1_idle_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ctrl_word == 32'h0));
endmodule

bind phyx_xreg_engine phyx_xreg_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .rd_data   (rd_data),
   .ctrl_word (ctrl_word)
);

// File: tb/phyx_xreg_engine_bench.sv
`timescale 1ns/1ps
module phyx_xreg_engine_bench;
   localparam int POLL = 4;
   localparam int MAXP = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        busy, done, err;
   logic [15:0] rd_data;
   logic [31:0] ctrl_word;
   logic [31:0] stat_word;

   int compared = 0;
   int mismatched = 0;

   always #4 clk = ~clk;

   phyx_xreg_engine #(.ADDR_W(16), .DATA_W(16), .POLL_CYC(POLL), .MAX_POLLS(MAXP))
   u_phyx_xreg_engine (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .err(err), .rd_data(rd_data), .ctrl_word(ctrl_word), .stat_word(stat_word)
   );

   // ---------------- behavioural PHY responder ----------------
   int          lat = 0;
   bit          stuck_lo = 0;
   bit          stuck_hi = 0;
   logic        ack_r;
   int          wait_cnt;
   logic [15:0] ph_addr, ph_data, ph_rd;
   logic [15:0] phy_mem [int];

   function automatic logic [15:0] phy_lookup(logic [15:0] a);
      if (phy_mem.exists(int'(a))) return phy_mem[int'(a)];
      return a ^ 16'h5A5A;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_r <= 1'b0; wait_cnt <= 0; ph_addr <= '0; ph_data <= '0; ph_rd <= '0;
      end else begin
         if ((|ctrl_word[19:16]) != ack_r) begin
            if (wait_cnt >= lat) begin ack_r <= |ctrl_word[19:16]; wait_cnt <= 0; end
            else wait_cnt <= wait_cnt + 1;
         end else wait_cnt <= 0;
         if (ctrl_word[16]) ph_addr <= ctrl_word[15:0];
         if (ctrl_word[17]) ph_data <= ctrl_word[15:0];
         if (ctrl_word[18]) phy_mem[int'(ph_addr)] = ph_data;
         ph_rd <= phy_lookup(ph_addr);
      end
   end

   assign stat_word = {15'h0, stuck_lo ? 1'b0 : (stuck_hi ? 1'b1 : ack_r), ph_rd};

   // ---------------- cycle reference model ----------------
   typedef struct {
      logic [31:0] c;
      int          kind;   // 0 one cycle, 1 wait high, 2 wait low, 3 done, 4 error
      bit          latch;
      string       tag;
   } step_t;

   step_t       q[$];
   int          tick = 0;
   int          polls = 0;
   logic [15:0] rd_m = '0;

   function automatic step_t mk(logic [31:0] c, int kind, bit latch, string tag);
      step_t s;
      s.c = c; s.kind = kind; s.latch = latch; s.tag = tag;
      return s;
   endfunction

   task automatic build(bit w, logic [15:0] a, logic [15:0] d);
      q.push_back(mk({16'h0, a}, 0, 0, "R3"));
      q.push_back(mk({16'h1, a}, 1, 0, "R3 R6"));
      q.push_back(mk({16'h0, a}, 2, 0, "R3 R6"));
      if (!w) begin
         q.push_back(mk(32'h0008_0000, 1, 1, "R4 R6"));
         q.push_back(mk(32'h0, 2, 0, "R4 R6"));
      end else begin
         q.push_back(mk({16'h0, d}, 0, 0, "R5"));
         q.push_back(mk({16'h2, d}, 1, 0, "R5 R6"));
         q.push_back(mk({16'h0, d}, 2, 0, "R5 R6"));
         q.push_back(mk(32'h0004_0000, 1, 0, "R5 R6"));
         q.push_back(mk({16'h0, d}, 2, 0, "R5 R6"));
      end
      q.push_back(mk(32'h0, 3, 0, "R8"));
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         q.delete(); tick = 0; polls = 0; rd_m = '0;
      end else begin
         logic [31:0] e_c; bit e_b, e_d, e_e; string tg;
         if (q.size() == 0) begin
            e_c = 0; e_b = 0; e_d = 0; e_e = 0; tg = "R8";
         end else begin
            e_c = q[0].c; e_b = 1; e_d = (q[0].kind == 3); e_e = (q[0].kind == 4); tg = q[0].tag;
         end
         compared++;
         if (ctrl_word !== e_c || busy !== e_b || done !== e_d || err !== e_e || rd_data !== rd_m) begin
            mismatched++;
            $display("FAIL %s cycle trace: ctrl=%h busy=%b done=%b err=%b rd=%h expected ctrl=%h busy=%b done=%b err=%b rd=%h",
                     tg, ctrl_word, busy, done, err, rd_data, e_c, e_b, e_d, e_e, rd_m);
         end
         if (q.size() == 0) begin
            if (req_valid) begin build(req_write, req_addr, req_wdata); tick = 0; polls = 0; end
         end else if (q[0].kind == 1 || q[0].kind == 2) begin
            if (tick == 0) begin
               if ((q[0].kind == 1) == stat_word[16]) begin
                  if (q[0].latch) rd_m = stat_word[15:0];
                  void'(q.pop_front()); polls = 0;
               end else begin
                  polls++;
                  if (polls >= MAXP) begin
                     q.delete(); q.push_back(mk(32'h0, 4, 0, "R7")); polls = 0;
                  end else tick = POLL - 1;
               end
            end else tick--;
         end else begin
            void'(q.pop_front()); tick = 0; polls = 0;
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(bit w, logic [15:0] a, logic [15:0] d, bit intrude,
                         output bit got_done, output bit got_err);
      got_done = 0; got_err = 0;
      @(posedge clk); #2;
      req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
      @(posedge clk); #2;
      req_valid = 0;
      if (intrude) begin
         repeat (5) @(posedge clk);
         #2; req_valid = 1; req_write = 1; req_addr = a; req_wdata = 16'h0000;
         @(posedge clk); #2; req_valid = 0;
      end
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (done) got_done = 1;
         if (err) got_err = 1;
         if (got_done || got_err) break;
      end
      @(negedge clk);
   endtask

   task automatic do_write(logic [15:0] a, logic [15:0] d);
      bit dn, er;
      access(1, a, d, 0, dn, er);
      check(dn && !er, "R5 write completes", {30'h0, dn, er}, 32'h2);
   endtask

   task automatic do_read(logic [15:0] a, logic [15:0] exp, bit intrude, string tag);
      bit dn, er;
      access(0, a, 16'h0, intrude, dn, er);
      check(dn && !er, "R4 read completes", {30'h0, dn, er}, 32'h2);
      check(rd_data == exp, tag, {16'h0, rd_data}, {16'h0, exp});
   endtask

   task automatic do_fail(logic [15:0] a, string tag);
      bit dn, er;
      access(1, a, 16'h1111, 0, dn, er);
      check(er && !dn, tag, {30'h0, dn, er}, 32'h1);
      check(!busy && ctrl_word == 0, "R7 idle after abort", ctrl_word, 32'h0);
   endtask

   initial begin
      bit dn, er;
      repeat (4) @(negedge clk);
      check(ctrl_word == 0 && !busy && !done && !err && rd_data == 0, "R1 reset state",
            {busy, done, err, 13'h0, rd_data}, 32'h0);
      @(posedge clk); #2; rst_n = 1;
      @(negedge clk);
      check(ctrl_word == 0 && !busy, "R1 after release", ctrl_word, 32'h0);

      lat = 0;
      do_write(16'h0012, 16'hBEEF);
      do_read(16'h0012, 16'hBEEF, 0, "R4 readback zero latency");
      do_read(16'h0400, 16'h0400 ^ 16'h5A5A, 0, "R4 unwritten register");

      lat = 3;
      do_write(16'h7FFF, 16'h1234);
      do_write(16'h0001, 16'hA5A5);
      do_read(16'h7FFF, 16'h1234, 0, "R5 data placed at own address");
      do_read(16'h0001, 16'hA5A5, 0, "R5 second write");

      lat = 34;
      do_read(16'h0012, 16'hBEEF, 0, "R6 ack near last sample");

      lat = 2;
      do_read(16'h0001, 16'hA5A5, 1, "R8 read with intruding request");
      do_read(16'h0001, 16'hA5A5, 0, "R8 intruding write ignored");

      lat = 0; stuck_lo = 1;
      do_fail(16'h0030, "R7 timeout waiting high");
      stuck_lo = 0;
      do_read(16'h0012, 16'hBEEF, 0, "R7 recovery after abort");

      stuck_hi = 1;
      do_fail(16'h0031, "R7 timeout waiting low");
      stuck_hi = 0;
      repeat (3) @(negedge clk);

      lat = 60;
      do_fail(16'h0032, "R7 latency beyond window");
      lat = 0;
      repeat (70) @(negedge clk);
      do_read(16'h0032, 16'h0032 ^ 16'h5A5A, 0, "R7 aborted write left no data");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule